// File: doc/BRIEF.md
# Bayer Optical Black Clamp

This block is the first stage of a raw Bayer pixel pipeline. It receives pixels of up to 10 bits together with frame and line markers and follows the column and line of every pixel. Within a fixed 16-column by 128-line measurement window, placed anywhere in the frame, it sums the incoming black pixels. When the frame ends, it publishes the window mean to a control processor.

Each pixel also passes through a single-register arithmetic stage. That stage removes a processor-written black level, adds a signed offset, scales by an unsigned fixed-point gain, and saturates the result to the 10-bit range. Offset and gain are chosen per Bayer colour phase, which comes from the pixel's column and line parity combined with a programmable starting phase. Sensors with 8 or 9 bits are supported by left-aligning their samples to 10 bits.

Top module: `bayer_black_clamp`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset, out_valid, out_pixel, black_avg and avg_done are all 0.
- R2: out_valid equals pix_valid delayed by one clock. out_pixel is 0 in any cycle where out_valid is 0.
- R3: Coordinates are counted only on valid pixels. A valid pixel with frame_start is at column 0, line 0. A valid pixel with line_start is at column 0 of the next line. Every other valid pixel is one column to the right of the previous one.
- R4: The phase index is {line[0], column[0]} XOR bayer_start. Phase k takes its gain from phase_gain[8k+7:8k] and its offset from phase_offset[10k+9:10k].
- R5: out_pixel = ((n - black_level + off) * gain) >> 6. Here n is the normalized input, off is the phase offset read as 10-bit two's complement, and gain is unsigned with 2 integer and 6 fraction bits.
- R6: When n - black_level + off is below zero, the result is 0. When the scaled value exceeds 1023, the result is 1023. Neither case wraps.
- R7: width_mode 1 maps pix_data[8:0] to {pix_data[8:0],0}. width_mode 2 maps pix_data[7:0] to {pix_data[7:0],00}. Modes 0 and 3 use all 10 bits. Bits above the selected width are ignored.
- R8: A normalized valid pixel is added to the window sum only if its column lies in [win_col, win_col+15] and its line lies in [win_line, win_line+127]. A frame_start pixel restarts the sum with only its own contribution.
- R9: One cycle after a frame_end pulse, black_avg holds the window sum shifted right by 11 and avg_done is high for one cycle. The sum restarts from 0 at that point.
- R10: black_avg changes only in a cycle where avg_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | 10 | Raw sensor sample |
| frame_start | input | 1 | First pixel of the frame (with pix_valid) |
| line_start | input | 1 | First pixel of a new line (with pix_valid) |
| frame_end | input | 1 | One-cycle pulse after the frame's last pixel |
| win_col | input | 12 | First column of the measurement window |
| win_line | input | 12 | First line of the measurement window |
| black_level | input | 10 | Level subtracted from each pixel |
| bayer_start | input | 2 | Phase of the pixel at column 0, line 0 |
| width_mode | input | 2 | Sensor sample width select |
| phase_offset | input | 40 | Four signed 10-bit offsets, phase 0 in the low bits |
| phase_gain | input | 32 | Four unsigned 2.6 gains, phase 0 in the low bits |
| out_valid | output | 1 | Output pixel qualifier |
| out_pixel | output | 10 | Clamped, offset and scaled pixel |
| black_avg | output | 10 | Window mean of the last completed frame |
| avg_done | output | 1 | One-cycle pulse when black_avg is updated |

## Verification
A wrong column or line count appears at the ports on the very next valid pixel: it uses the wrong phase's gain and offset, so the bench sets the four phases far apart to make such a slip visible. The same wrong count only moves samples into or out of the window sum, and that error stays hidden until the next frame end, where black_avg differs from the reference. Arithmetic errors are visible one cycle after the pixel enters. Saturation faults need inputs that drive the intermediate value both below zero and above full scale, and the frames with a high black level and a large gain provide those.

// File: rtl/bob_pkg.sv
package bob_pkg;

    typedef enum logic [1:0] {
        WMODE_FULL  = 2'd0,
        WMODE_NINE  = 2'd1,
        WMODE_EIGHT = 2'd2,
        WMODE_ALT   = 2'd3
    } width_mode_e;

    localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/bob_coord.sv
module bob_coord #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             sof,
    input  logic             sol,
    output logic [CNT_W-1:0] col,
    output logic [CNT_W-1:0] line
);
    typedef struct packed {
        logic [CNT_W-1:0] col;
        logic [CNT_W-1:0] line;
    } coord_t;

    coord_t st_d, st_q;

    always_comb begin
        col  = st_q.col + CNT_W'(1);
        line = st_q.line;
        if (sof) begin
            col  = '0;
            line = '0;
        end else if (sol) begin
            col  = '0;
            line = st_q.line + CNT_W'(1);
        end
        st_d = st_q;
        if (valid) begin
            st_d.col  = col;
            st_d.line = line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bob_meter.sv
module bob_meter #(
    parameter int unsigned PIX_W = 10,
    parameter int unsigned CNT_W = 12,
    parameter int unsigned WIN_W = 16,
    parameter int unsigned WIN_H = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             sof,
    input  logic             frame_end,
    input  logic [PIX_W-1:0] pix,
    input  logic [CNT_W-1:0] col,
    input  logic [CNT_W-1:0] line,
    input  logic [CNT_W-1:0] win_col,
    input  logic [CNT_W-1:0] win_line,
    output logic [PIX_W-1:0] avg,
    output logic             done
);
    localparam int unsigned SHIFT = $clog2(WIN_W * WIN_H);
    localparam int unsigned ACC_W = PIX_W + SHIFT;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PIX_W-1:0] avg;
        logic             done;
    } meter_t;

    meter_t st_d, st_q;
    logic   in_win;
    logic [CNT_W:0] col_end, line_end;

    always_comb begin
        col_end  = {1'b0, win_col}  + (CNT_W+1)'(WIN_W);
        line_end = {1'b0, win_line} + (CNT_W+1)'(WIN_H);
        in_win = (col >= win_col) && ({1'b0, col} < col_end) &&
                 (line >= win_line) && ({1'b0, line} < line_end);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (frame_end) begin
            st_d.avg  = st_q.acc[SHIFT +: PIX_W];
            st_d.done = 1'b1;
            st_d.acc  = '0;
        end else if (valid) begin
            if (sof) st_d.acc = in_win ? ACC_W'(pix) : '0;
            else if (in_win) st_d.acc = st_q.acc + ACC_W'(pix);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg  = st_q.avg;
    assign done = st_q.done;
endmodule

// File: rtl/bob_pixel.sv
module bob_pixel #(
    parameter int unsigned PIX_W     = 10,
    parameter int unsigned GAIN_W    = 8,
    parameter int unsigned GAIN_FRAC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  black,
    input  logic [PIX_W-1:0]  offset,
    input  logic [GAIN_W-1:0] gain,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int unsigned SUM_W  = PIX_W + 3;
    localparam int unsigned POS_W  = PIX_W + 1;
    localparam int unsigned PROD_W = POS_W + GAIN_W;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } stage_t;

    stage_t st_d, st_q;
    logic signed [SUM_W-1:0] lvl;
    logic [POS_W-1:0]  pos;
    logic [PROD_W-1:0] prod, scaled;

    always_comb begin
        lvl = $signed({3'b000, pix}) - $signed({3'b000, black})
            + $signed({{3{offset[PIX_W-1]}}, offset});
        pos = lvl[SUM_W-1] ? '0 : lvl[POS_W-1:0];
        prod   = PROD_W'(pos) * PROD_W'(gain);
        scaled = prod >> GAIN_FRAC;
        st_d.vld = valid;
        st_d.pix = '0;
        if (valid)
            st_d.pix = (|scaled[PROD_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;
endmodule

// File: rtl/bayer_black_clamp.sv
module bayer_black_clamp #(
    parameter int unsigned PIX_W     = 10,
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned WIN_W     = 16,
    parameter int unsigned WIN_H     = 128,
    parameter int unsigned GAIN_W    = 8,
    parameter int unsigned GAIN_FRAC = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pix_valid,
    input  logic [PIX_W-1:0]                     pix_data,
    input  logic                                 frame_start,
    input  logic                                 line_start,
    input  logic                                 frame_end,
    input  logic [CNT_W-1:0]                     win_col,
    input  logic [CNT_W-1:0]                     win_line,
    input  logic [PIX_W-1:0]                     black_level,
    input  logic [1:0]                           bayer_start,
    input  logic [1:0]                           width_mode,
    input  logic [bob_pkg::NUM_PHASES*PIX_W-1:0]  phase_offset,
    input  logic [bob_pkg::NUM_PHASES*GAIN_W-1:0] phase_gain,
    output logic                                 out_valid,
    output logic [PIX_W-1:0]                     out_pixel,
    output logic [PIX_W-1:0]                     black_avg,
    output logic                                 avg_done
);
    import bob_pkg::*;

    logic [CNT_W-1:0]  col, line;
    logic [PIX_W-1:0]  norm;
    logic [1:0]        phase;
    logic [PIX_W-1:0]  sel_off [NUM_PHASES];
    logic [GAIN_W-1:0] sel_gain[NUM_PHASES];

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
        assign sel_off[k]  = phase_offset[k*PIX_W +: PIX_W];
        assign sel_gain[k] = phase_gain[k*GAIN_W +: GAIN_W];
    end

    always_comb begin
        case (width_mode_e'(width_mode))
            WMODE_NINE:  norm = {pix_data[PIX_W-2:0], 1'b0};
            WMODE_EIGHT: norm = {pix_data[PIX_W-3:0], 2'b00};
            default:     norm = pix_data;
        endcase
        phase = {line[0], col[0]} ^ bayer_start;
    end

    bob_coord #(.CNT_W(CNT_W)) u_coord (
        .clk(clk), .rst_n(rst_n), .valid(pix_valid),
        .sof(frame_start), .sol(line_start), .col(col), .line(line)
    );

    bob_meter #(.PIX_W(PIX_W), .CNT_W(CNT_W), .WIN_W(WIN_W), .WIN_H(WIN_H)) u_meter (
        .clk(clk), .rst_n(rst_n), .valid(pix_valid), .sof(frame_start),
        .frame_end(frame_end), .pix(norm), .col(col), .line(line),
        .win_col(win_col), .win_line(win_line), .avg(black_avg), .done(avg_done)
    );

    bob_pixel #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_pixel (
        .clk(clk), .rst_n(rst_n), .valid(pix_valid), .pix(norm),
        .black(black_level), .offset(sel_off[phase]), .gain(sel_gain[phase]),
        .out_valid(out_valid), .out_pix(out_pixel)
    );
endmodule

// File: rtl/bob_checker.sv
module bob_checker #(
    parameter int unsigned PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             frame_end,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pixel,
    input logic [PIX_W-1:0] black_avg,
    input logic             avg_done
);
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_pixel == '0);

    p_done_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        avg_done |-> $past(frame_end));

    p_avg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_done |-> $stable(black_avg));
endmodule

bind bayer_black_clamp bob_checker #(.PIX_W(PIX_W)) u_bob_checker (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_end(frame_end),
    .out_valid(out_valid), .out_pixel(out_pixel), .black_avg(black_avg),
    .avg_done(avg_done)
);

// File: tb/bayer_black_clamp_bench.sv
`timescale 1ns/1ps
module bayer_black_clamp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0, frame_start = 1'b0, line_start = 1'b0, frame_end = 1'b0;
    logic [9:0]  pix_data = '0, black_level = '0;
    logic [11:0] win_col = '0, win_line = '0;
    logic [1:0]  bayer_start = '0, width_mode = '0;
    logic [39:0] phase_offset = '0;
    logic [31:0] phase_gain = '0;
    logic        out_valid, avg_done;
    logic [9:0]  out_pixel, black_avg;

    always #2.5 clk = ~clk;

    bayer_black_clamp u_bayer_black_clamp (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .frame_start(frame_start), .line_start(line_start), .frame_end(frame_end),
        .win_col(win_col), .win_line(win_line), .black_level(black_level),
        .bayer_start(bayer_start), .width_mode(width_mode),
        .phase_offset(phase_offset), .phase_gain(phase_gain),
        .out_valid(out_valid), .out_pixel(out_pixel),
        .black_avg(black_avg), .avg_done(avg_done)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    // reference model state
    int mx = 0, my = 0, msum = 0;
    bit exp_valid = 0, exp_done = 0;
    int exp_pix = 0, exp_avg = 0;
    string exp_tag = "R2";

    task automatic check(input string tag, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int normalize(input int d);
        case (width_mode)
            2'd1: return (d & 10'h1FF) << 1;
            2'd2: return (d & 10'h0FF) << 2;
            default: return d & 10'h3FF;
        endcase
    endfunction

    task automatic step(input bit v, input int d, input bit s, input bit l, input bit fe);
        int raw, ph, o, g, t, p;
        @(negedge clk);
        check("R2 valid", out_valid, exp_valid);
        check(exp_tag, out_pixel, exp_pix);
        check("R9 done", avg_done, exp_done);
        check(exp_done ? "R9 avg" : "R10 avg", black_avg, exp_avg);
        pix_valid = v; pix_data = 10'(d); frame_start = s & v;
        line_start = l & v; frame_end = fe;
        exp_done = fe;
        if (fe) begin
            exp_avg = msum >> 11;
            msum = 0;
        end
        exp_valid = v;
        exp_pix = 0;
        exp_tag = "R2 idle";
        if (v) begin
            // R3 coordinate rules
            if (s) begin mx = 0; my = 0; msum = 0; end
            else if (l) begin mx = 0; my++; end
            else mx++;
            raw = normalize(d);
            // R8 window membership
            if (!fe && mx >= win_col && mx < win_col + 16 && my >= win_line && my < win_line + 128)
                msum += raw;
            // R4 phase selection
            ph = (((my & 1) << 1) | (mx & 1)) ^ bayer_start;
            o = phase_offset[ph*10 +: 10];
            if (o >= 512) o -= 1024;
            g = phase_gain[ph*8 +: 8];
            t = raw - black_level + o;
            exp_tag = (width_mode == 1 || width_mode == 2) ? "R7 R4 pixel" : "R5 R4 pixel";
            if (t < 0) begin t = 0; exp_tag = "R6 low"; end
            p = (t * g) >> 6;
            if (p > 1023) begin p = 1023; exp_tag = "R6 high"; end
            exp_pix = p;
        end
    endtask

    task automatic frame(input int cols, input int lines, input bit gaps);
        for (int y = 0; y < lines; y++) begin
            for (int x = 0; x < cols; x++) begin
                if (gaps && ($urandom % 6 == 0)) step(0, $urandom, 1, 1, 0);
                step(1, $urandom % 1024, (x == 0 && y == 0), (x == 0 && y != 0), 0);
            end
        end
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 out_valid", out_valid, 0);
        check("R1 out_pixel", out_pixel, 0);
        check("R1 black_avg", black_avg, 0);
        check("R1 avg_done", avg_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {out_valid, avg_done, out_pixel, black_avg}, 0);

        // frame 1: unity gain, no offset, full window
        win_col = 4; win_line = 2; black_level = 0; bayer_start = 0; width_mode = 0;
        phase_gain = {8'd64, 8'd64, 8'd64, 8'd64};
        phase_offset = '0;
        frame(24, 134, 0);

        // frame 2: distinct phases, 9-bit mode, gaps, saturation both ways
        win_col = 0; win_line = 0; black_level = 64; bayer_start = 2; width_mode = 1;
        phase_gain = {8'd200, 8'd32, 8'd128, 8'd64};
        phase_offset = {10'd0, 10'd30, 10'd5, 10'(-20)};
        frame(18, 130, 1);

        // frame 3: 8-bit mode, partial window, high black level
        win_col = 30; win_line = 10; black_level = 600; bayer_start = 3; width_mode = 2;
        phase_gain = {8'd255, 8'd0, 8'd100, 8'd70};
        phase_offset = {10'(-100), 10'd200, 10'd511, 10'(-512)};
        frame(40, 20, 1);

        // frame 4: mode 3 uses full width
        win_col = 1; win_line = 1; black_level = 10; bayer_start = 1; width_mode = 3;
        phase_gain = {8'd96, 8'd64, 8'd48, 8'd160};
        phase_offset = {10'd12, 10'(-4), 10'd0, 10'd100};
        frame(20, 132, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule